// File: doc/BRIEF.md
# Long-Format Translation Table Walker

This block resolves one virtual address into a physical address by walking a tree of 64-bit long-format translation descriptors. A request supplies the virtual address, the base of the first table, a granule selection (4 KB, 16 KB or 64 KB) and the level at which the walk begins. The walker then reads one descriptor per level through a simple memory read port. It classifies each descriptor as table, block, page or invalid and either descends to the next level or stops.

While descending, the walker gathers the restrictions that table descriptors place on everything below them: execute-never, privileged execute-never, read-only, no-unprivileged-access and non-secure. At a leaf it reports the physical address, the width of the page or block offset, the leaf attributes with those restrictions merged in, and the level where the walk ended. An unusable descriptor ends the walk with a translation fault that carries the level at which it was found.

The block is meant to sit behind a TLB miss path. One walk is in flight at a time, and a new request is taken only when the walker is idle.

Top module: `desc_walker`

## Requirements
- R1: After reset `walkBusy`, `memReqValid` and `doneValid` are low. A request is taken only when `reqValid` is high while `walkBusy` is low. Requests raised while busy are ignored and do not alter the result of the walk in progress.
- R2: Each level visited costs exactly one read: `memReqValid` is high for one cycle with the descriptor address, and the walker waits for `memRspValid` before it decodes. `doneValid` pulses for one cycle per walk.
- R3: Granule code 0 means 4 KB (g = 12), code 1 means 16 KB (g = 14), code 2 means 64 KB (g = 16), and code 3 behaves as 4 KB. The index at level L is VA[lo+s-1:lo], where s = g-3 and lo = s*(3-L)+g. VA bits above the VA width read as zero. The first read address is the table base ORed with index<<3. Each later read address is descriptor bits [47:g] (with bits [g-1:0] cleared) ORed with index<<3.
- R4: Descriptor type bits [1:0] = 11 decode as a page at level 3 and as a table at levels 0 to 2. The codes 00 and 10 are invalid at every level.
- R5: Type bits 01 decode as a block only at levels 1 and 2 for the 4 KB granule, and only at level 2 for the 16 KB and 64 KB granules. Anywhere else they are invalid.
- R6: The reported offset width is g for a page. For a block it is 30 at level 1 and 21 at level 2 with 4 KB, 25 with 16 KB, and 29 with 64 KB.
- R7: The physical address is descriptor bits [47:n] joined with VA bits [n-1:0], where n is the offset width. Descriptor address bits below n are discarded.
- R8: Leaf fields are taken from these bit positions: XN bit 54, PXN bit 53, contiguous bit 52, not-global bit 11, access flag bit 10, shareability [9:8], access permission [7:6] (bit 7 read-only, bit 6 unprivileged access), NS bit 5 and attribute index [4:2]. The reported XN is the leaf XN ORed with every table bit 60 on the path. The reported PXN is the leaf PXN ORed with every table bit 59.
- R9: A table bit 62 anywhere on the path forces the reported AP[1] (read-only) to 1. A table bit 61 anywhere on the path forces the reported AP[0] (unprivileged access) to 0.
- R10: `doneGlobal` is 1 when `reqElHigh` was set with the request. Otherwise it is the inverse of leaf bit 11.
- R11: `doneSecure` is 1 only when the request was secure, no table on the path had bit 63 set, and the leaf NS bit 5 is clear.
- R12: An invalid descriptor ends the walk with `doneFault` set, `doneLevel` equal to the level of the failing read, and `donePa`, the offset width and all attribute outputs at zero. A successful walk reports the leaf level on `doneLevel` with `doneFault` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVa | input | VA_WIDTH | Virtual address to translate |
| reqTableBase | input | PA_WIDTH | Base address of the first table |
| reqGranule | input | 2 | Granule code: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB |
| reqStartLevel | input | 2 | Level of the first lookup |
| reqSecure | input | 1 | Lookup is secure |
| reqElHigh | input | 1 | Request comes from exception level 2 or 3 |
| walkBusy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | Descriptor read strobe |
| memReqAddr | output | PA_WIDTH | Descriptor read address |
| memRspValid | input | 1 | Descriptor read data valid |
| memRspData | input | 64 | Descriptor read data |
| doneValid | output | 1 | One-cycle completion pulse |
| doneFault | output | 1 | Translation fault |
| doneLevel | output | 2 | Level at which the walk ended |
| donePa | output | PA_WIDTH | Translated physical address |
| doneOffsetBits | output | 6 | Page or block offset width |
| doneXn | output | 1 | Merged execute-never |
| donePxn | output | 1 | Merged privileged execute-never |
| doneContig | output | 1 | Contiguous hint |
| doneGlobal | output | 1 | Translation is global |
| doneAf | output | 1 | Access flag |
| doneSh | output | 2 | Shareability |
| doneAp | output | 2 | Merged access permission |
| doneSecure | output | 1 | Output address is secure |
| doneAttrIdx | output | 3 | Memory attribute index |

## Verification
The bench's memory model answers only at the addresses it was loaded with and returns zero elsewhere. A wrong index slice, granule mask or level counter therefore turns into a fault or an extra read, visible at the next `doneValid` pulse, and the bench counts the reads of every walk. A wrong type decode or block-legality decision shows as a fault where a leaf was expected, or the reverse, at the level the walk reached. A bad offset mask shows in the low bits of `donePa`, because the leaf descriptors carry stray address bits below the offset width. Restriction bits that are not accumulated correctly appear only in the merged XN, PXN, AP and secure outputs of the leaf that follows the table that set them.

// File: rtl/desc_walker_pkg.sv
package desc_walker_pkg;

  localparam int DescWidth = 64;

  typedef enum logic [1:0] {
    KIND_INVALID = 2'd0,
    KIND_TABLE   = 2'd1,
    KIND_BLOCK   = 2'd2,
    KIND_PAGE    = 2'd3
  } descKind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new request
    logic step;    // descend through a table descriptor
    logic finish;  // capture a leaf or a fault
  } walkStrobe_t;

  // granule code to log2 of the granule size
  function automatic logic [4:0] granuleBits(input logic [1:0] sel);
    case (sel)
      2'd1:    return 5'd14;
      2'd2:    return 5'd16;
      default: return 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/desc_walker_ctrl.sv
module desc_walker_ctrl
  import desc_walker_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRspValid,
  input  descKind_e   descKind,
  output walkStrobe_t strobe,
  output logic        walkBusy,
  output logic        memReqValid,
  output logic        doneValid
);

  walkState_e stateQ, stateD;

  always_comb begin
    strobe        = '0;
    stateD        = stateQ;
    strobe.load   = (stateQ == ST_IDLE) && reqValid;
    strobe.step   = (stateQ == ST_WAIT) && memRspValid && (descKind == KIND_TABLE);
    strobe.finish = (stateQ == ST_WAIT) && memRspValid && (descKind != KIND_TABLE);
    case (stateQ)
      ST_IDLE:  if (reqValid) stateD = ST_ISSUE;
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) stateD = (descKind == KIND_TABLE) ? ST_ISSUE : ST_DONE;
      end
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign walkBusy    = (stateQ != ST_IDLE);
  assign memReqValid = (stateQ == ST_ISSUE);
  assign doneValid   = (stateQ == ST_DONE);

  // a read strobe never lasts longer than one cycle
  assert_single_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // the first read follows the accepted request directly
  assert_load_issues_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> memReqValid);

  // completion returns the walker to idle
  assert_done_frees_R1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !walkBusy);

endmodule

// File: rtl/desc_walker_dpath.sv
module desc_walker_dpath
  import desc_walker_pkg::*;
#(
  parameter int VA_WIDTH = 48,
  parameter int PA_WIDTH = 48
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walkStrobe_t           strobe,
  input  logic [VA_WIDTH-1:0]   reqVa,
  input  logic [PA_WIDTH-1:0]   reqTableBase,
  input  logic [1:0]            reqGranule,
  input  logic [1:0]            reqStartLevel,
  input  logic                  reqSecure,
  input  logic                  reqElHigh,
  input  logic [DescWidth-1:0]  memRspData,
  output descKind_e             descKind,
  output logic [PA_WIDTH-1:0]   memReqAddr,
  output logic                  doneFault,
  output logic [1:0]            doneLevel,
  output logic [PA_WIDTH-1:0]   donePa,
  output logic [5:0]            doneOffsetBits,
  output logic                  doneXn,
  output logic                  donePxn,
  output logic                  doneContig,
  output logic                  doneGlobal,
  output logic                  doneAf,
  output logic [1:0]            doneSh,
  output logic [1:0]            doneAp,
  output logic                  doneSecure,
  output logic [2:0]            doneAttrIdx
);

  localparam int ExtWidth = 64;

  // walk context
  logic [VA_WIDTH-1:0] vaQ;
  logic [1:0]          granQ;
  logic [1:0]          levelQ;
  logic                secureQ;
  logic                elHighQ;
  logic [PA_WIDTH-1:0] descAddrQ;
  // restrictions gathered from table descriptors
  logic xnTQ, pxnTQ, nsTQ, readOnlyTQ, noUserTQ;

  // byte offset of the descriptor selected by va at a level
  function automatic logic [ExtWidth-1:0] indexOffset(
      input logic [ExtWidth-1:0] va, input logic [1:0] gran, input logic [1:0] lvl);
    logic [4:0] gb;
    logic [4:0] st;
    logic [6:0] lo;
    logic [ExtWidth-1:0] mask;
    gb   = granuleBits(gran);
    st   = gb - 5'd3;
    lo   = 7'(st) * 7'(2'd3 - lvl) + 7'(gb);
    mask = (ExtWidth'(1) << st) - ExtWidth'(1);
    return ((va >> lo) & mask) << 3;
  endfunction

  logic [4:0]          gBits;
  logic [PA_WIDTH-1:0] rspAddr;
  logic [PA_WIDTH-1:0] granMask;
  logic [PA_WIDTH-1:0] nextAddr;
  logic [PA_WIDTH-1:0] firstAddr;
  logic                blockLegal;
  logic [5:0]          leafBits;
  logic [PA_WIDTH-1:0] leafMask;
  logic [PA_WIDTH-1:0] leafPa;
  logic [1:0]          nextLevel;

  always_comb begin
    gBits     = granuleBits(granQ);
    rspAddr   = memRspData[PA_WIDTH-1:0];
    granMask  = (PA_WIDTH'(1) << gBits) - PA_WIDTH'(1);
    nextLevel = levelQ + 2'd1;
    nextAddr  = (rspAddr & ~granMask)
              | PA_WIDTH'(indexOffset(ExtWidth'(vaQ), granQ, nextLevel));
    firstAddr = reqTableBase
              | PA_WIDTH'(indexOffset(ExtWidth'(reqVa), reqGranule, reqStartLevel));

    // block legality depends on granule and level
    if (granQ == 2'd1 || granQ == 2'd2) blockLegal = (levelQ == 2'd2);
    else                                blockLegal = (levelQ == 2'd1) || (levelQ == 2'd2);

    case (memRspData[1:0])
      2'b11:   descKind = (levelQ == 2'd3) ? KIND_PAGE : KIND_TABLE;
      2'b01:   descKind = blockLegal ? KIND_BLOCK : KIND_INVALID;
      default: descKind = KIND_INVALID;
    endcase

    // offset width of the leaf
    if (descKind == KIND_PAGE) begin
      leafBits = 6'(gBits);
    end else begin
      case (granQ)
        2'd1:    leafBits = 6'd25;
        2'd2:    leafBits = 6'd29;
        default: leafBits = (levelQ == 2'd1) ? 6'd30 : 6'd21;
      endcase
    end
    leafMask = (PA_WIDTH'(1) << leafBits) - PA_WIDTH'(1);
    leafPa   = (rspAddr & ~leafMask) | (PA_WIDTH'(vaQ) & leafMask);
  end

  assign memReqAddr = descAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ            <= '0;
      granQ          <= '0;
      levelQ         <= '0;
      secureQ        <= 1'b0;
      elHighQ        <= 1'b0;
      descAddrQ      <= '0;
      xnTQ           <= 1'b0;
      pxnTQ          <= 1'b0;
      nsTQ           <= 1'b0;
      readOnlyTQ     <= 1'b0;
      noUserTQ       <= 1'b0;
      doneFault      <= 1'b0;
      doneLevel      <= '0;
      donePa         <= '0;
      doneOffsetBits <= '0;
      doneXn         <= 1'b0;
      donePxn        <= 1'b0;
      doneContig     <= 1'b0;
      doneGlobal     <= 1'b0;
      doneAf         <= 1'b0;
      doneSh         <= '0;
      doneAp         <= '0;
      doneSecure     <= 1'b0;
      doneAttrIdx    <= '0;
    end else begin
      if (strobe.load) begin
        vaQ        <= reqVa;
        granQ      <= reqGranule;
        levelQ     <= reqStartLevel;
        secureQ    <= reqSecure;
        elHighQ    <= reqElHigh;
        descAddrQ  <= firstAddr;
        xnTQ       <= 1'b0;
        pxnTQ      <= 1'b0;
        nsTQ       <= 1'b0;
        readOnlyTQ <= 1'b0;
        noUserTQ   <= 1'b0;
      end else if (strobe.step) begin
        levelQ     <= nextLevel;
        descAddrQ  <= nextAddr;
        nsTQ       <= nsTQ       | memRspData[63];
        readOnlyTQ <= readOnlyTQ | memRspData[62];
        noUserTQ   <= noUserTQ   | memRspData[61];
        xnTQ       <= xnTQ       | memRspData[60];
        pxnTQ      <= pxnTQ      | memRspData[59];
      end
      if (strobe.finish) begin
        doneLevel <= levelQ;
        if (descKind == KIND_INVALID) begin
          doneFault      <= 1'b1;
          donePa         <= '0;
          doneOffsetBits <= '0;
          doneXn         <= 1'b0;
          donePxn        <= 1'b0;
          doneContig     <= 1'b0;
          doneGlobal     <= 1'b0;
          doneAf         <= 1'b0;
          doneSh         <= '0;
          doneAp         <= '0;
          doneSecure     <= 1'b0;
          doneAttrIdx    <= '0;
        end else begin
          doneFault      <= 1'b0;
          donePa         <= leafPa;
          doneOffsetBits <= leafBits;
          doneXn         <= memRspData[54] | xnTQ;
          donePxn        <= memRspData[53] | pxnTQ;
          doneContig     <= memRspData[52];
          doneGlobal     <= elHighQ | ~memRspData[11];
          doneAf         <= memRspData[10];
          doneSh         <= memRspData[9:8];
          doneAp         <= {memRspData[7] | readOnlyTQ, memRspData[6] & ~noUserTQ};
          doneSecure     <= secureQ & ~nsTQ & ~memRspData[5];
          doneAttrIdx    <= memRspData[4:2];
        end
      end
    end
  end

  // a table is never taken at the last level, so the level never wraps
  assert_no_table_at_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> levelQ != 2'd3);

  assert_level_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> levelQ == $past(levelQ) + 2'd1);

  assert_xn_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && xnTQ) |=> (doneFault || doneXn));

  assert_read_only_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && readOnlyTQ) |=> (doneFault || doneAp[1]));

  assert_high_el_global_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && elHighQ) |=> (doneFault || doneGlobal));

  assert_fault_level_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> doneLevel == $past(levelQ));

endmodule

// File: rtl/desc_walker.sv
module desc_walker
  import desc_walker_pkg::*;
#(
  parameter int VA_WIDTH = 48,
  parameter int PA_WIDTH = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [VA_WIDTH-1:0]  reqVa,
  input  logic [PA_WIDTH-1:0]  reqTableBase,
  input  logic [1:0]           reqGranule,
  input  logic [1:0]           reqStartLevel,
  input  logic                 reqSecure,
  input  logic                 reqElHigh,
  output logic                 walkBusy,
  output logic                 memReqValid,
  output logic [PA_WIDTH-1:0]  memReqAddr,
  input  logic                 memRspValid,
  input  logic [63:0]          memRspData,
  output logic                 doneValid,
  output logic                 doneFault,
  output logic [1:0]           doneLevel,
  output logic [PA_WIDTH-1:0]  donePa,
  output logic [5:0]           doneOffsetBits,
  output logic                 doneXn,
  output logic                 donePxn,
  output logic                 doneContig,
  output logic                 doneGlobal,
  output logic                 doneAf,
  output logic [1:0]           doneSh,
  output logic [1:0]           doneAp,
  output logic                 doneSecure,
  output logic [2:0]           doneAttrIdx
);

  walkStrobe_t strobe;
  descKind_e   descKind;

  desc_walker_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .descKind    (descKind),
    .strobe      (strobe),
    .walkBusy    (walkBusy),
    .memReqValid (memReqValid),
    .doneValid   (doneValid)
  );

  desc_walker_dpath #(
    .VA_WIDTH (VA_WIDTH),
    .PA_WIDTH (PA_WIDTH)
  ) uDpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .reqVa          (reqVa),
    .reqTableBase   (reqTableBase),
    .reqGranule     (reqGranule),
    .reqStartLevel  (reqStartLevel),
    .reqSecure      (reqSecure),
    .reqElHigh      (reqElHigh),
    .memRspData     (memRspData),
    .descKind       (descKind),
    .memReqAddr     (memReqAddr),
    .doneFault      (doneFault),
    .doneLevel      (doneLevel),
    .donePa         (donePa),
    .doneOffsetBits (doneOffsetBits),
    .doneXn         (doneXn),
    .donePxn        (donePxn),
    .doneContig     (doneContig),
    .doneGlobal     (doneGlobal),
    .doneAf         (doneAf),
    .doneSh         (doneSh),
    .doneAp         (doneAp),
    .doneSecure     (doneSecure),
    .doneAttrIdx    (doneAttrIdx)
  );

endmodule

// File: tb/desc_walker_test.sv
module desc_walker_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [47:0] reqVa = '0;
  logic [47:0] reqTableBase = '0;
  logic [1:0]  reqGranule = '0;
  logic [1:0]  reqStartLevel = '0;
  logic        reqSecure = 1'b0;
  logic        reqElHigh = 1'b0;
  logic        walkBusy, memReqValid, memRspValid, doneValid;
  logic [47:0] memReqAddr;
  logic [63:0] memRspData;
  logic        doneFault, doneXn, donePxn, doneContig, doneGlobal, doneAf, doneSecure;
  logic [1:0]  doneLevel, doneSh, doneAp;
  logic [47:0] donePa;
  logic [5:0]  doneOffsetBits;
  logic [2:0]  doneAttrIdx;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  desc_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqTableBase(reqTableBase), .reqGranule(reqGranule),
    .reqStartLevel(reqStartLevel), .reqSecure(reqSecure), .reqElHigh(reqElHigh),
    .walkBusy(walkBusy), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .doneValid(doneValid),
    .doneFault(doneFault), .doneLevel(doneLevel), .donePa(donePa),
    .doneOffsetBits(doneOffsetBits), .doneXn(doneXn), .donePxn(donePxn),
    .doneContig(doneContig), .doneGlobal(doneGlobal), .doneAf(doneAf),
    .doneSh(doneSh), .doneAp(doneAp), .doneSecure(doneSecure),
    .doneAttrIdx(doneAttrIdx)
  );

  // sparse descriptor memory: unknown addresses read as zero (invalid)
  logic [47:0] memA [16];
  logic [63:0] memD [16];
  int          memN = 0;
  logic        pend;
  logic [47:0] pendAddr;
  int          fetchCnt;

  function automatic logic [63:0] memLook(input logic [47:0] a);
    for (int i = 0; i < 16; i++) if (i < memN && memA[i] == a) return memD[i];
    return 64'd0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend <= 1'b0; pendAddr <= '0; memRspValid <= 1'b0; memRspData <= '0; fetchCnt <= 0;
    end else begin
      pend        <= memReqValid;
      pendAddr    <= memReqAddr;
      memRspValid <= pend;
      memRspData  <= pend ? memLook(pendAddr) : 64'd0;
      if (memReqValid) fetchCnt <= fetchCnt + 1;
    end
  end

  task automatic putDesc(input logic [47:0] a, input logic [63:0] d);
    memA[memN] = a; memD[memN] = d; memN++;
  endtask

  function automatic logic [63:0] tblDesc(input logic [47:0] base, input logic nsT,
      input logic [1:0] apT, input logic xnT, input logic pxnT);
    logic [63:0] d;
    d = {16'd0, base} | 64'h3;
    d[63] = nsT; d[62:61] = apT; d[60] = xnT; d[59] = pxnT;
    return d;
  endfunction

  function automatic logic [63:0] leafDesc(input logic [47:0] outA, input logic isPage,
      input logic xn, input logic pxn, input logic cont, input logic ng, input logic af,
      input logic [1:0] sh, input logic [1:0] ap, input logic ns, input logic [2:0] attr);
    logic [63:0] d;
    d = {16'd0, outA} | (isPage ? 64'h3 : 64'h1);
    d[54] = xn; d[53] = pxn; d[52] = cont; d[11] = ng; d[10] = af;
    d[9:8] = sh; d[7:6] = ap; d[5] = ns; d[4:2] = attr;
    return d;
  endfunction

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  int lastFetches;

  // starts a walk and waits for completion; optional stray requests while busy
  task automatic runWalk(input logic [47:0] va, input logic [47:0] base,
      input logic [1:0] gran, input logic [1:0] start, input logic sec,
      input logic elh, input logic stray);
    int startCnt;
    bit seen;
    @(negedge clk);
    startCnt = fetchCnt;
    reqValid = 1'b1; reqVa = va; reqTableBase = base; reqGranule = gran;
    reqStartLevel = start; reqSecure = sec; reqElHigh = elh;
    @(negedge clk);
    if (stray) begin
      reqVa = 48'h0000_7FFF_F000; reqTableBase = 48'h0; reqGranule = 2'd2;
      reqStartLevel = 2'd3; reqSecure = ~sec; reqElHigh = ~elh;
      @(negedge clk);
      @(negedge clk);
    end
    reqValid = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 100 && !seen; i++) begin
      if (doneValid) seen = 1'b1;
      else @(negedge clk);
    end
    if (!seen) begin
      checks++; errors++;
      $display("FAIL R2 walk timeout actual=0 expected=1");
    end
    lastFetches = fetchCnt - startCnt;
    @(negedge clk);
  endtask

  task automatic clearMem();
    memN = 0;
  endtask

  // R3 R4 R6 R7 R8: 4 KB walk from level 0 to a level-3 page
  task automatic testFullWalk4k();
    logic [47:0] va;
    va = {9'd1, 9'd2, 9'd3, 9'd4, 12'hABC};
    clearMem();
    putDesc(48'h10_0008, tblDesc(48'h20_0000, 0, 2'b00, 0, 0));
    putDesc(48'h20_0010, tblDesc(48'h30_0000, 0, 2'b00, 0, 0));
    putDesc(48'h30_0018, tblDesc(48'h40_0000, 0, 2'b00, 0, 0));
    putDesc(48'h40_0020, leafDesc(48'h1234_5000, 1, 0, 1, 1, 1, 1, 2'b11, 2'b01, 0, 3'd5));
    runWalk(va, 48'h10_0000, 2'd0, 2'd0, 0, 0, 0);
    checkEq("R2 four reads", lastFetches, 4);
    checkEq("R4 page no fault", doneFault, 0);
    checkEq("R12 leaf level 3", doneLevel, 3);
    checkEq("R7 page pa", donePa, 48'h1234_5ABC);
    checkEq("R6 page offset 12", doneOffsetBits, 12);
    checkEq("R8 attrs", {doneXn, donePxn, doneContig, doneAf, doneSh, doneAp, doneAttrIdx},
            {1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 2'b01, 3'd5});
    checkEq("R10 not global", doneGlobal, 0);
    checkEq("R11 nonsecure lookup", doneSecure, 0);
  endtask

  // R5 R6 R7 R10 R11 R1: 4 KB level-1 block, stray requests while busy
  task automatic testBlock1g();
    logic [47:0] va;
    va = {9'd0, 9'd7, 30'h0123_4567};
    clearMem();
    putDesc(48'h50_0038, leafDesc(48'h8100_0000, 0, 1, 0, 0, 1, 0, 2'b00, 2'b00, 0, 3'd0));
    runWalk(va, 48'h50_0000, 2'd0, 2'd1, 1, 1, 1);
    checkEq("R1 stray ignored reads", lastFetches, 1);
    checkEq("R5 L1 block legal 4k", doneFault, 0);
    checkEq("R6 block offset 30", doneOffsetBits, 30);
    checkEq("R7 block pa drops low desc bits", donePa, 48'h8123_4567);
    checkEq("R10 high EL global", doneGlobal, 1);
    checkEq("R11 secure leaf", doneSecure, 1);
    checkEq("R8 leaf xn", doneXn, 1);
  endtask

  // R8 R9 R11 R6: 4 KB level-2 block under a restricting table
  task automatic testRestricted();
    logic [47:0] va;
    va = {9'd0, 9'd3, 9'd5, 21'h0A_BCDE};
    clearMem();
    putDesc(48'h60_0018, tblDesc(48'h70_0000, 1, 2'b11, 1, 1));
    putDesc(48'h70_0028, leafDesc(48'h4060_0000, 0, 0, 0, 0, 0, 1, 2'b10, 2'b01, 0, 3'd2));
    runWalk(va, 48'h60_0000, 2'd0, 2'd1, 1, 0, 0);
    checkEq("R6 block offset 21", doneOffsetBits, 21);
    checkEq("R7 2M pa", donePa, 48'h406A_BCDE);
    checkEq("R8 xn pxn merged", {doneXn, donePxn}, 2'b11);
    checkEq("R9 ap restricted", doneAp, 2'b10);
    checkEq("R11 ns table forces nonsecure", doneSecure, 0);
    checkEq("R10 ng clear is global", doneGlobal, 1);
    checkEq("R12 level 2", doneLevel, 2);
  endtask

  // R3 R6: 16 KB, table base with stray low bits, level-2 block
  task automatic testBlock16k();
    logic [47:0] va;
    va = {1'b0, 11'd9, 11'd6, 25'h1AB_CDEF};
    clearMem();
    putDesc(48'h80_0048, tblDesc(48'h90_2000, 0, 2'b00, 0, 0));
    putDesc(48'h90_0030, leafDesc(48'h2000_0000, 0, 0, 0, 0, 0, 1, 2'b01, 2'b00, 0, 3'd1));
    runWalk(va, 48'h80_0000, 2'd1, 2'd1, 0, 0, 0);
    checkEq("R3 16k index and base mask", doneFault, 0);
    checkEq("R6 16k block offset 25", doneOffsetBits, 25);
    checkEq("R7 16k pa", donePa, 48'h21AB_CDEF);
  endtask

  // R3 R4 R6: 64 KB page from level 2
  task automatic testPage64k();
    logic [47:0] va;
    va = {6'd0, 13'd17, 13'd33, 16'h4321};
    clearMem();
    putDesc(48'h0A_0088, tblDesc(48'h0B_0000, 0, 2'b00, 0, 0));
    putDesc(48'h0B_0108, leafDesc(48'h7777_0000, 1, 0, 0, 0, 0, 1, 2'b00, 2'b00, 1, 3'd7));
    runWalk(va, 48'h0A_0000, 2'd2, 2'd2, 1, 0, 0);
    checkEq("R3 64k two reads", lastFetches, 2);
    checkEq("R6 64k page offset 16", doneOffsetBits, 16);
    checkEq("R7 64k pa", donePa, 48'h7777_4321);
    checkEq("R11 leaf ns", doneSecure, 0);
  endtask

  // R5 R12 R4: faults at various levels
  task automatic testFaults();
    clearMem();
    putDesc(48'h80_0048, leafDesc(48'h4000_0000, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 3'd0));
    runWalk({1'b0, 11'd9, 11'd6, 25'h0}, 48'h80_0000, 2'd1, 2'd1, 0, 0, 0);
    checkEq("R5 16k L1 block faults", {doneFault, doneLevel}, {1'b1, 2'd1});
    checkEq("R12 fault pa zero", donePa, 0);

    clearMem();
    putDesc(48'h10_0008, leafDesc(48'h0, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 3'd0));
    runWalk({9'd1, 9'd2, 9'd3, 9'd4, 12'h0}, 48'h10_0000, 2'd0, 2'd0, 0, 0, 0);
    checkEq("R5 4k L0 block faults", {doneFault, doneLevel}, {1'b1, 2'd0});

    clearMem();
    putDesc(48'hD0_0020, leafDesc(48'h5000, 0, 0, 0, 0, 0, 1, 2'b00, 2'b00, 0, 3'd0));
    runWalk({9'd1, 9'd2, 9'd3, 9'd4, 12'h0}, 48'hD0_0000, 2'd0, 2'd3, 0, 0, 0);
    checkEq("R5 4k L3 block faults", {doneFault, doneLevel}, {1'b1, 2'd3});

    clearMem();
    putDesc(48'h30_0018, 64'h2);
    runWalk({9'd1, 9'd2, 9'd3, 9'd4, 12'h0}, 48'h30_0000, 2'd0, 2'd2, 0, 0, 0);
    checkEq("R4 R12 type 10 invalid at L2", {doneFault, doneLevel}, {1'b1, 2'd2});
    checkEq("R12 fault offset and attrs zero", {doneOffsetBits, doneAp, doneSh, doneGlobal}, 0);
    checkEq("R2 fault one read", lastFetches, 1);
  endtask

  bit finished = 0;

  initial begin
    #1ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkEq("R1 reset outputs", {walkBusy, memReqValid, doneValid}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 idle after reset", {walkBusy, memReqValid, doneValid}, 3'b000);
    testFullWalk4k();
    testBlock1g();
    testRestricted();
    testBlock16k();
    testPage64k();
    testFaults();
    checkEq("R1 idle at end", walkBusy, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule